// File: doc/BRIEF.md
# Bit-Serial Decimal Field Arithmetic Unit

This block is the datapath of a decimal floating-point engine. It keeps seven 56-bit words, each made of fourteen 4-bit BCD digits: three working words (A, B, C) and a four-level push-down stack (X, Y, Z, T). Every operation moves data one bit per clock. All seven words rotate together, least significant bit first, for one full word time of 56 clocks. The source digits are assembled on the fly and pass through a one-digit decimal adder/subtractor. The corrected digit is written back into the destination word only inside the digit field that the operation selected. Digits outside that field come back round unchanged.

A sequencer starts an operation by giving an operation code, a field code, two source codes and a destination code, then holding `start` high for one cycle. The block reports completion with `done`. The carry or borrow out of the most significant digit of the selected field is left in `cy_flag`, ready for a conditional branch. Values from outside enter as a source: source code 7 streams a word that is captured from `ext_word` when the operation is accepted. Any word can be read back through `rd_sel`/`rd_word` while the block is idle.

Top module: `bcd_serial_au`

## Requirements
- R1: After reset all seven words read as zero, and `cy_flag`, `busy` and `done` are 0.
- R2: When `start` is high while `busy` is low, the inputs are captured and `busy` is high for exactly 56 cycles. `done` is a one-cycle pulse in the first cycle with `busy` low again. A `start` seen while `busy` is high is ignored.
- R3: Digit 0 is the least significant digit, held in bits 3:0. Field codes: 0 whole word (digits 0-13), 1 mantissa (3-12), 2 mantissa sign (13), 3 exponent (0-1), 4 exponent sign (2), 5 the single digit given by `dig_sel` (a value above 13 selects no digit), 6 and 7 whole word. Destination digits outside the field keep their value.
- R4: Op 0 (add) writes P+Q in decimal into the field, rippling the decimal carry upward from the lowest field digit. `cy_flag` becomes the carry out of the top field digit.
- R5: Op 1 (subtract) writes P-Q in decimal, with the borrow rippling upward, and `cy_flag` becomes the borrow out of the top field digit. Op 2 (compare) sets `cy_flag` the same way and writes nothing.
- R6: Op 3 (increment) writes P+1 and op 4 (decrement) writes P-1 into the field, with Q ignored. `cy_flag` is the carry or borrow out of the field.
- R7: Op 5 (shift up) moves each field digit of P one place toward the more significant end. Op 6 (shift down) moves each one place toward the less significant end. Both fill the vacated end digit of the field with 0 and leave `cy_flag` at 0.
- R8: Op 7 (move) copies the field of P into the destination. Destination codes are 0 A, 1 B, 2 C, 3 X, so Y, Z and T are never written by arithmetic or move.
- R9: Op 8 (push) sets T to old Z, Z to old Y, Y to old X, and X to P, always on whole words. `cy_flag` becomes 0.
- R10: Op 9 (pop) sets X to old Y, Y to old Z, and Z to old T, and leaves T unchanged. `cy_flag` becomes 0.
- R11: Source codes are 0 A, 1 B, 2 C, 3 X, 4 Y, 5 Z, 6 T and 7 the captured `ext_word`. Op codes 10 to 15 change no word and leave `cy_flag` at 0. An empty field gives `cy_flag` 0.
- R12: While `busy` is low, no word changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start an operation (taken when idle) |
| op_code | input | 4 | Operation code |
| fld_code | input | 3 | Field code |
| dig_sel | input | 4 | Digit index for the single-digit field |
| src_p | input | 3 | First source code |
| src_q | input | 3 | Second source code |
| dst_sel | input | 2 | Destination code |
| ext_word | input | 56 | External word, captured at start |
| rd_sel | input | 3 | Read-back select (source encoding) |
| rd_word | output | 56 | Read-back word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cy_flag | output | 1 | Carry/borrow out of the selected field |

## Verification
The checker watches the timing contract on every cycle: `busy` rising after an accepted start, `done` as a single pulse with `busy` low, words frozen while idle, compare issuing no write, writes falling only on the last bit of a digit, and the T word's bit stream during push and pop. Decimal results, field masking, carry and borrow across digits, shift fill and the flag value depend on the whole 56-cycle pass. Only the bench's scenarios can show them, and it does so by comparing all seven words and the flag against its own digit-level model after each operation.

// File: rtl/bcd_su_pkg.sv
package bcd_su_pkg;
  localparam int NDIG  = 14;
  localparam int DW    = 4;
  localparam int WBITS = NDIG * DW;
  localparam int NREG  = 7;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_CMP  = 4'd2;
  localparam logic [3:0] OP_INC  = 4'd3;
  localparam logic [3:0] OP_DEC  = 4'd4;
  localparam logic [3:0] OP_SHL  = 4'd5;
  localparam logic [3:0] OP_SHR  = 4'd6;
  localparam logic [3:0] OP_MOV  = 4'd7;
  localparam logic [3:0] OP_PUSH = 4'd8;
  localparam logic [3:0] OP_POP  = 4'd9;

  localparam logic [2:0] F_WORD  = 3'd0;
  localparam logic [2:0] F_MANT  = 3'd1;
  localparam logic [2:0] F_MSGN  = 3'd2;
  localparam logic [2:0] F_EXP   = 3'd3;
  localparam logic [2:0] F_ESGN  = 3'd4;
  localparam logic [2:0] F_DIGIT = 3'd5;

  localparam int REG_X = 3;
  localparam int REG_Y = 4;
  localparam int REG_Z = 5;
  localparam int REG_T = 6;
  localparam logic [2:0] SRC_EXT = 3'd7;

  localparam int EXP_LO  = 0;
  localparam int EXP_HI  = 1;
  localparam int ESGN_D  = 2;
  localparam int MANT_LO = 3;
  localparam int MANT_HI = 12;
  localparam int MSGN_D  = 13;

  typedef struct packed {
    logic [4:0] lo;
    logic [4:0] hi;
  } span_t;

  function automatic span_t field_span(input logic [2:0] f, input logic [3:0] idx);
    span_t s;
    case (f)
      F_MANT:  begin s.lo = 5'(MANT_LO); s.hi = 5'(MANT_HI); end
      F_MSGN:  begin s.lo = 5'(MSGN_D);  s.hi = 5'(MSGN_D);  end
      F_EXP:   begin s.lo = 5'(EXP_LO);  s.hi = 5'(EXP_HI);  end
      F_ESGN:  begin s.lo = 5'(ESGN_D);  s.hi = 5'(ESGN_D);  end
      F_DIGIT: begin
        if (int'(idx) < NDIG) begin s.lo = {1'b0, idx}; s.hi = {1'b0, idx}; end
        else begin s.lo = 5'd31; s.hi = 5'd0; end
      end
      default: begin s.lo = 5'd0; s.hi = 5'(NDIG - 1); end
    endcase
    return s;
  endfunction

  // {carry, digit} of p + q + cin in decimal
  function automatic logic [4:0] dec_add(input logic [3:0] p, input logic [3:0] q, input logic cin);
    logic [4:0] s;
    s = {1'b0, p} + {1'b0, q} + {4'b0, cin};
    if (s > 5'd9) return {1'b1, 4'(s - 5'd10)};
    return {1'b0, s[3:0]};
  endfunction

  // {borrow, digit} of p - q - bin in decimal
  function automatic logic [4:0] dec_sub(input logic [3:0] p, input logic [3:0] q, input logic bin);
    logic [5:0] d;
    d = {2'b0, p} - {2'b0, q} - {5'b0, bin};
    if (d[5]) return {1'b1, 4'(d[3:0] + 4'd10)};
    return {1'b0, d[3:0]};
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) ||
           (op == OP_INC) || (op == OP_DEC);
  endfunction
endpackage

// File: rtl/bcd_word_timer.sv
module bcd_word_timer
  import bcd_su_pkg::*;
#(
  parameter int ND = NDIG,
  parameter int BPD = DW,
  localparam int BW = $clog2(BPD),
  localparam int DGW = $clog2(ND)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           accept,
  output logic           busy,
  output logic           done,
  output logic           last,
  output logic [BW-1:0]  bit_idx,
  output logic [DGW-1:0] dig_idx
);
  localparam logic [BW-1:0]  BIT_LAST = BW'(BPD - 1);
  localparam logic [DGW-1:0] DIG_LAST = DGW'(ND - 1);

  assign accept = start && !busy;
  assign last   = busy && (bit_idx == BIT_LAST) && (dig_idx == DIG_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      bit_idx <= '0;
      dig_idx <= '0;
    end else begin
      done <= last;
      if (accept) begin
        busy    <= 1'b1;
        bit_idx <= '0;
        dig_idx <= '0;
      end else if (busy) begin
        if (bit_idx == BIT_LAST) begin
          bit_idx <= '0;
          if (dig_idx == DIG_LAST) begin
            dig_idx <= '0;
            busy    <= 1'b0;
          end else begin
            dig_idx <= dig_idx + 1'b1;
          end
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_digit_alu.sv
module bcd_digit_alu
  import bcd_su_pkg::*;
#(
  parameter int ND = NDIG,
  parameter int BPD = DW,
  localparam int BW = $clog2(BPD),
  localparam int DGW = $clog2(ND)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           busy,
  input  logic [BW-1:0]  bit_idx,
  input  logic [DGW-1:0] dig_idx,
  input  logic [3:0]     op,
  input  logic [4:0]     lo,
  input  logic [4:0]     hi,
  input  logic           p_bit,
  input  logic           q_bit,
  output logic           wr_cur,
  output logic [BPD-1:0] cur_val,
  output logic           wr_prev,
  output logic [BPD-1:0] prev_val,
  output logic           flag
);
  localparam logic [BW-1:0] BIT_LAST = BW'(BPD - 1);

  logic [BPD-2:0] sp, sq;
  logic [BPD-1:0] pd, qd, prevp;
  logic [4:0]     dig5, calc;
  logic           at_b3, in_f, cin, cy_q, unary, use_sub;

  assign at_b3   = busy && (bit_idx == BIT_LAST);
  assign dig5    = 5'(dig_idx);
  assign in_f    = (dig5 >= lo) && (dig5 <= hi);
  assign unary   = (op == OP_INC) || (op == OP_DEC);
  assign use_sub = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
  assign pd      = {p_bit, sp};
  assign qd      = unary ? '0 : {q_bit, sq};
  assign cin     = (dig5 == lo) ? unary : cy_q;
  assign calc    = use_sub ? dec_sub(pd, qd, cin) : dec_add(pd, qd, cin);

  always_comb begin
    wr_cur   = 1'b0;
    cur_val  = calc[3:0];
    wr_prev  = 1'b0;
    prev_val = pd;
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: wr_cur = at_b3 && in_f;
      OP_MOV: begin
        wr_cur  = at_b3 && in_f;
        cur_val = pd;
      end
      OP_SHL: begin
        wr_cur  = at_b3 && in_f;
        cur_val = (dig5 > lo) ? prevp : '0;
      end
      OP_SHR: begin
        wr_cur  = at_b3 && in_f && (dig5 == hi);
        cur_val = '0;
        wr_prev = at_b3 && in_f && (dig5 > lo);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= '0;
      sq    <= '0;
      prevp <= '0;
      cy_q  <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (accept) flag <= 1'b0;
      if (busy && !at_b3) begin
        sp <= {p_bit, sp[BPD-2:1]};
        sq <= {q_bit, sq[BPD-2:1]};
      end
      if (at_b3) begin
        prevp <= pd;
        if (in_f) cy_q <= calc[4];
        if (in_f && (dig5 == hi) && is_arith(op)) flag <= calc[4];
      end
    end
  end
endmodule

// File: rtl/bcd_reg_bank.sv
module bcd_reg_bank
  import bcd_su_pkg::*;
#(
  parameter int NR = NREG,
  parameter int BPD = DW,
  parameter int W = WBITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           busy,
  input  logic [3:0]     op,
  input  logic [1:0]     dst,
  input  logic [2:0]     psel,
  input  logic [2:0]     qsel,
  input  logic [W-1:0]   ext_word,
  input  logic           wr_cur,
  input  logic [BPD-1:0] cur_val,
  input  logic           wr_prev,
  input  logic [BPD-1:0] prev_val,
  input  logic [2:0]     rd_sel,
  output logic           p_bit,
  output logic           q_bit,
  output logic [W-1:0]   rd_word,
  output logic [NR*W-1:0] regs_flat
);
  logic [W-1:0] ext_q;
  logic         lsb  [NR];
  logic         in_b [NR];

  always_ff @(posedge clk) begin
    if (!rst_n)      ext_q <= '0;
    else if (accept) ext_q <= ext_word;
    else if (busy)   ext_q <= {ext_q[0], ext_q[W-1:1]};
  end

  assign p_bit = (psel == SRC_EXT) ? ext_q[0] : lsb[psel];
  assign q_bit = (qsel == SRC_EXT) ? ext_q[0] : lsb[qsel];

  always_comb begin
    for (int i = 0; i < NR; i++) in_b[i] = lsb[i];
    if (op == OP_PUSH) begin
      in_b[REG_X] = p_bit;
      in_b[REG_Y] = lsb[REG_X];
      in_b[REG_Z] = lsb[REG_Y];
      in_b[REG_T] = lsb[REG_Z];
    end else if (op == OP_POP) begin
      in_b[REG_X] = lsb[REG_Y];
      in_b[REG_Y] = lsb[REG_Z];
      in_b[REG_Z] = lsb[REG_T];
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [W-1:0] r, nxt;
    logic         is_dst;
    assign is_dst = ({1'b0, dst} == 3'(g));
    assign lsb[g] = r[0];
    assign regs_flat[g*W +: W] = r;
    always_comb begin
      nxt = {in_b[g], r[W-1:1]};
      if (wr_cur && is_dst)  nxt[W-1 -: BPD]     = cur_val;
      if (wr_prev && is_dst) nxt[W-BPD-1 -: BPD] = prev_val;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    r <= '0;
      else if (busy) r <= nxt;
    end
  end

  assign rd_word = (rd_sel == SRC_EXT) ? ext_q : regs_flat[int'(rd_sel)*W +: W];
endmodule

// File: rtl/bcd_serial_au.sv
module bcd_serial_au
  import bcd_su_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op_code,
  input  logic [2:0]        fld_code,
  input  logic [3:0]        dig_sel,
  input  logic [2:0]        src_p,
  input  logic [2:0]        src_q,
  input  logic [1:0]        dst_sel,
  input  logic [WBITS-1:0]  ext_word,
  input  logic [2:0]        rd_sel,
  output logic [WBITS-1:0]  rd_word,
  output logic              busy,
  output logic              done,
  output logic              cy_flag
);
  localparam int BW  = $clog2(DW);
  localparam int DGW = $clog2(NDIG);

  logic             accept, last;
  logic [BW-1:0]    bit_idx;
  logic [DGW-1:0]   dig_idx;
  logic [3:0]       op_q;
  logic [1:0]       dst_q;
  logic [2:0]       psel_q, qsel_q;
  span_t            span_q;
  logic             p_bit, q_bit, wr_cur, wr_prev;
  logic [DW-1:0]    cur_val, prev_val;
  logic [NREG*WBITS-1:0] regs_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= 4'hF;
      dst_q  <= '0;
      psel_q <= '0;
      qsel_q <= '0;
      span_q <= '0;
    end else if (accept) begin
      op_q   <= op_code;
      dst_q  <= dst_sel;
      psel_q <= src_p;
      qsel_q <= src_q;
      span_q <= field_span(fld_code, dig_sel);
    end
  end

  bcd_word_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .done(done), .last(last), .bit_idx(bit_idx), .dig_idx(dig_idx)
  );

  bcd_digit_alu u_alu (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
    .bit_idx(bit_idx), .dig_idx(dig_idx), .op(op_q),
    .lo(span_q.lo), .hi(span_q.hi), .p_bit(p_bit), .q_bit(q_bit),
    .wr_cur(wr_cur), .cur_val(cur_val), .wr_prev(wr_prev),
    .prev_val(prev_val), .flag(cy_flag)
  );

  bcd_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .op(op_q),
    .dst(dst_q), .psel(psel_q), .qsel(qsel_q), .ext_word(ext_word),
    .wr_cur(wr_cur), .cur_val(cur_val), .wr_prev(wr_prev),
    .prev_val(prev_val), .rd_sel(rd_sel), .p_bit(p_bit), .q_bit(q_bit),
    .rd_word(rd_word), .regs_flat(regs_flat)
  );
endmodule

// File: rtl/bcd_serial_au_chk.sv
module bcd_serial_au_chk
  import bcd_su_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [3:0]             op_q,
  input logic [1:0]             bit_idx,
  input logic                   wr_cur,
  input logic                   wr_prev,
  input logic [NREG*WBITS-1:0]  regs_flat
);
  logic t_msb, t_lsb, z_lsb;
  assign t_msb = regs_flat[REG_T*WBITS + WBITS - 1];
  assign t_lsb = regs_flat[REG_T*WBITS];
  assign z_lsb = regs_flat[REG_Z*WBITS];

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy) else $error("busy did not rise");  // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy");  // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(regs_flat)) else $error("word changed while idle");  // R12
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_CMP) |-> !(wr_cur || wr_prev)) else $error("compare wrote");  // R5
  AST_WRITE_DIGIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur || wr_prev) |-> (busy && bit_idx == 2'(DW - 1))) else $error("misaligned write");  // R3
  AST_POP_T_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_POP) |=> (t_msb == $past(t_lsb))) else $error("pop altered T");  // R10
  AST_PUSH_T_FROM_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_PUSH) |=> (t_msb == $past(z_lsb))) else $error("push T not from Z");  // R9
endmodule

bind bcd_serial_au bcd_serial_au_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .op_q(op_q), .bit_idx(bit_idx), .wr_cur(wr_cur), .wr_prev(wr_prev),
  .regs_flat(regs_flat)
);

// File: tb/bcd_serial_au_tb.sv
`timescale 1ns/1ps
module bcd_serial_au_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [2:0]  fld_code = 3'd0;
  logic [3:0]  dig_sel = 4'd0;
  logic [2:0]  src_p = 3'd0, src_q = 3'd0, rd_sel = 3'd0;
  logic [1:0]  dst_sel = 2'd0;
  logic [55:0] ext_word = '0;
  logic [55:0] rd_word;
  logic        busy, done, cy_flag;

  int n_chk = 0, n_err = 0;
  bit ended = 0;
  logic [55:0] m [7];
  logic        m_flag;

  always #2 clk = ~clk;

  bcd_serial_au dut_i (.*);

  task automatic chk(string rq, logic [55:0] act, logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [55:0] rnd_bcd();
    logic [55:0] w;
    for (int i = 0; i < 14; i++) w[4*i +: 4] = 4'($urandom % 10);
    return w;
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R4";
      4'd1, 4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  // field bounds per R3; empty field gives lo > hi
  task automatic span(input logic [2:0] f, input logic [3:0] idx, output int lo, output int hi);
    case (f)
      3'd1: begin lo = 3;  hi = 12; end
      3'd2: begin lo = 13; hi = 13; end
      3'd3: begin lo = 0;  hi = 1;  end
      3'd4: begin lo = 2;  hi = 2;  end
      3'd5: begin if (idx <= 13) begin lo = idx; hi = idx; end else begin lo = 1; hi = 0; end end
      default: begin lo = 0; hi = 13; end
    endcase
  endtask

  task automatic model(logic [3:0] op, logic [2:0] f, logic [3:0] idx,
                       logic [2:0] p, logic [2:0] q, logic [1:0] d, logic [55:0] ext);
    logic [55:0] pw, qw, res;
    int lo, hi, a, b, t, c;
    pw = (p == 3'd7) ? ext : m[p];
    qw = (q == 3'd7) ? ext : m[q];
    span(f, idx, lo, hi);
    res = m[d];
    m_flag = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
        c = (op == 4'd3 || op == 4'd4) ? 1 : 0;
        for (int i = lo; i <= hi; i++) begin
          a = int'(pw[4*i +: 4]);
          b = (op == 4'd3 || op == 4'd4) ? 0 : int'(qw[4*i +: 4]);
          if (op == 4'd1 || op == 4'd2 || op == 4'd4) begin
            t = a - b - c; c = (t < 0) ? 1 : 0; if (t < 0) t += 10;
          end else begin
            t = a + b + c; c = (t > 9) ? 1 : 0; if (t > 9) t -= 10;
          end
          res[4*i +: 4] = 4'(t);
        end
        m_flag = (hi >= lo) ? c[0] : 1'b0;
        if (op != 4'd2) m[d] = res;
      end
      4'd5: begin
        for (int i = lo; i <= hi; i++) res[4*i +: 4] = (i > lo) ? pw[4*(i-1) +: 4] : 4'd0;
        m[d] = res;
      end
      4'd6: begin
        for (int i = lo; i <= hi; i++) res[4*i +: 4] = (i < hi) ? pw[4*(i+1) +: 4] : 4'd0;
        m[d] = res;
      end
      4'd7: begin
        for (int i = lo; i <= hi; i++) res[4*i +: 4] = pw[4*i +: 4];
        m[d] = res;
      end
      4'd8: begin m[6] = m[5]; m[5] = m[4]; m[4] = m[3]; m[3] = pw; end
      4'd9: begin m[3] = m[4]; m[4] = m[5]; m[5] = m[6]; end
      default: ;
    endcase
  endtask

  task automatic compare_all(string rq);
    for (int s = 0; s < 7; s++) begin
      rd_sel = 3'(s);
      #0.1;
      chk(rq, rd_word, m[s]);
    end
    chk(rq, {55'd0, cy_flag}, {55'd0, m_flag});
  endtask

  // poke: pulse start with another op mid-run (must be ignored, R2)
  task automatic do_op(logic [3:0] op, logic [2:0] f, logic [3:0] idx, logic [2:0] p,
                       logic [2:0] q, logic [1:0] d, logic [55:0] ext, bit poke);
    int nb;
    @(negedge clk);
    op_code = op; fld_code = f; dig_sel = idx; src_p = p; src_q = q;
    dst_sel = d; ext_word = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ext_word = rnd_bcd();
    nb = 0;
    while (!done && nb < 200) begin
      if (busy) nb++;
      if (poke && nb == 20) begin op_code = 4'd8; src_p = 3'd7; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2", 56'(nb), 56'd56);
    chk("R2", {54'd0, busy, done}, {54'd0, 1'b0, 1'b1});
    model(op, f, idx, p, q, d, ext);
    compare_all(req_of(op));
    @(negedge clk);
    chk("R2", {54'd0, busy, done}, 56'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [55:0] snap [7];
    void'($urandom(32'd1357));
    for (int i = 0; i < 7; i++) m[i] = '0;
    m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_all("R1");
    chk("R1", {54'd0, busy, done}, 56'd0);

    // R8/R11 load words from the external source
    do_op(4'd7, 3'd0, 4'd0, 3'd7, 3'd0, 2'd0, 56'h99999999999999, 0);
    do_op(4'd7, 3'd0, 4'd0, 3'd7, 3'd0, 2'd1, 56'h00000000000001, 0);
    // R4 full ripple carry out of the word
    do_op(4'd0, 3'd0, 4'd0, 3'd0, 3'd1, 2'd2, '0, 0);
    // R3 mantissa-only add: carry stops at digit 12
    do_op(4'd7, 3'd0, 4'd0, 3'd7, 3'd0, 2'd1, 56'h00000000001000, 0);
    do_op(4'd0, 3'd1, 4'd0, 3'd0, 3'd1, 2'd2, '0, 0);
    // R5 subtract with borrow, then compare
    do_op(4'd1, 3'd0, 4'd0, 3'd1, 3'd0, 2'd2, '0, 0);
    do_op(4'd2, 3'd3, 4'd0, 3'd1, 3'd0, 2'd0, '0, 0);
    // R6 increment 9 in sign digit and decrement 0
    do_op(4'd3, 3'd2, 4'd0, 3'd0, 3'd1, 2'd2, '0, 0);
    do_op(4'd4, 3'd4, 4'd0, 3'd7, 3'd0, 2'd2, 56'h00000000000000, 0);
    // R7 shifts on mantissa and exponent
    do_op(4'd7, 3'd0, 4'd0, 3'd7, 3'd0, 2'd0, 56'h12345678901234, 0);
    do_op(4'd5, 3'd1, 4'd0, 3'd0, 3'd0, 2'd1, '0, 0);
    do_op(4'd6, 3'd1, 4'd0, 3'd0, 3'd0, 2'd0, '0, 0);
    do_op(4'd6, 3'd3, 4'd0, 3'd0, 3'd0, 2'd2, '0, 0);
    // R3 single digit and empty single-digit field
    do_op(4'd3, 3'd5, 4'd7, 3'd0, 3'd0, 2'd0, '0, 0);
    do_op(4'd3, 3'd5, 4'd15, 3'd0, 3'd0, 2'd0, '0, 0);
    // R9/R10 stack
    do_op(4'd8, 3'd1, 4'd0, 3'd7, 3'd0, 2'd0, 56'h11111111111111, 0);
    do_op(4'd8, 3'd0, 4'd0, 3'd7, 3'd0, 2'd0, 56'h22222222222222, 0);
    do_op(4'd8, 3'd0, 4'd0, 3'd7, 3'd0, 2'd0, 56'h33333333333333, 0);
    do_op(4'd8, 3'd0, 4'd0, 3'd7, 3'd0, 2'd0, 56'h44444444444444, 0);
    do_op(4'd9, 3'd0, 4'd0, 3'd0, 3'd0, 2'd0, '0, 0);
    // R11 unused code, R2 start ignored while busy
    do_op(4'd12, 3'd0, 4'd0, 3'd1, 3'd2, 2'd0, rnd_bcd(), 0);
    do_op(4'd0, 3'd0, 4'd0, 3'd0, 3'd1, 2'd1, '0, 1);

    for (int k = 0; k < 220; k++) begin
      do_op(4'($urandom % 12), 3'($urandom % 8), 4'($urandom % 16), 3'($urandom % 8),
            3'($urandom % 8), 2'($urandom % 4), rnd_bcd(), 0);
      if (k % 40 == 0) begin
        // R12 idle with changing inputs leaves every word alone
        for (int s = 0; s < 7; s++) begin rd_sel = 3'(s); #0.1; snap[s] = rd_word; end
        for (int j = 0; j < 6; j++) begin
          @(negedge clk);
          op_code = 4'($urandom); src_p = 3'($urandom); ext_word = rnd_bcd();
        end
        for (int s = 0; s < 7; s++) begin rd_sel = 3'(s); #0.1; chk("R12", rd_word, snap[s]); end
      end
    end
    finish_run();
  end
endmodule